// File: doc/BRIEF.md
# Fine Delay Code Tracking Controller

This block steers the small-step half of a two-loop delay-locked frequency discriminator. A separate coarse loop first settles a wide-range delay setting. Until that loop reports that it is done, this controller stays idle and holds its fine delay code at zero. Once the coarse loop is done, the controller reads the phase detector's early/late verdicts. On each accepted verdict it moves a 5-bit fine code by one step. The code feeds a tuning DAC (outside this block), so a slow drift of the input period is followed continuously.

The code only moves when a verdict strobe is present. After each step, a programmable quiet window passes before the next step, so that the analog tuning voltage can settle. The code stops at both ends. A saturation flag shows when the detector keeps pushing against an end. A lock flag reports that the loop is dithering around its balance point. The live code is the digital reading of how far the input frequency has shifted since the coarse loop settled. Tracking never stops after the first lock, and dropping the coarse-done input sends the block back to idle.

Top module: `fine_track_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `fine_code`, `fine_lock` and `fine_sat` are all 0 after that edge.
- R2: At any edge where `coarse_done` is 0, the code and both flags become 0 and all verdicts are discarded. A high-to-low change of `coarse_done` therefore returns the block to its idle state on the next edge.
- R3: An accepted verdict with `pd_up`=1 and `pd_dn`=0 (input period longer than the delay, so more delay is needed) raises `fine_code` by exactly 1 on that edge. `pd_up`=0 and `pd_dn`=1 lowers it by exactly 1.
- R4: An accepted verdict with `pd_up` and `pd_dn` equal (both 0 or both 1) is balanced and leaves `fine_code` unchanged.
- R5: After an edge that changes the code, verdict strobes sampled at the next MIN_GAP edges are ignored entirely. A blocked or balanced verdict does not start this window.
- R6: The code saturates at 0 and at 2^CODE_W-1. An accepted request to move past an end leaves the code unchanged and sets `fine_sat`. The next accepted verdict that is balanced or that moves the code clears it.
- R7: `fine_lock` is set by an accepted balanced verdict. It is also set by an accepted move request whose direction is opposite to the previous accepted verdict. It is cleared when an accepted move request has the same direction as the previous accepted verdict. A balanced verdict breaks this same-direction history.
- R8: Tracking continues with no restart. When the target delay changes after lock, the code follows it one step at a time while `coarse_done` stays high.
- R9: When `dec_vld` is 0, `pd_up` and `pd_dn` have no effect on the code or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_done | input | 1 | High while the coarse loop is settled; enables tracking |
| dec_vld | input | 1 | Strobe: phase detector verdict is valid this cycle |
| pd_up | input | 1 | Detector asks for more delay |
| pd_dn | input | 1 | Detector asks for less delay |
| fine_code | output | CODE_W | Fine delay code for the tuning DAC |
| fine_lock | output | 1 | Loop is balanced or dithering |
| fine_sat | output | 1 | Code pinned at an end while movement is still requested |

## Verification
The bench builds the block with CODE_W=5 and MIN_GAP=3. At that setting a full climb from 0 to 31 takes only about 130 cycles, so both saturation ends, the reversal lock and re-tracking after a target jump are all reached within a short run. The short gap still leaves several cycles inside each quiet window, where strobes must be ignored. The detector verdicts come from a model that compares the code with a target delay code that the bench moves, including targets beyond both ends.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  typedef enum logic [1:0] {
    REQ_HOLD = 2'd0,
    REQ_INC  = 2'd1,
    REQ_DEC  = 2'd2
  } req_e;
endpackage

// File: rtl/ftc_classify.sv
module ftc_classify
  import ftc_pkg::*;
(
  input  logic up,
  input  logic dn,
  output req_e req
);
  always_comb begin
    if (up && !dn)      req = REQ_INC;
    else if (dn && !up) req = REQ_DEC;
    else                req = REQ_HOLD;
  end
endmodule

// File: rtl/ftc_pacer.sv
module ftc_pacer #(
  parameter int MIN_GAP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic load,
  output logic ready
);
  localparam int GW = (MIN_GAP < 1) ? 1 : $clog2(MIN_GAP + 1);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt_q <= '0;
    else if (load)        cnt_q <= GW'(MIN_GAP);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/ftc_code_reg.sv
module ftc_code_reg
  import ftc_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              acc,
  input  req_e              req,
  output logic [CODE_W-1:0] code,
  output logic              blocked,
  output logic              stepped
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
  logic [CODE_W-1:0] code_q;

  assign blocked = (req == REQ_INC && code_q == TOP) ||
                   (req == REQ_DEC && code_q == '0);
  assign stepped = acc && (req != REQ_HOLD) && !blocked;

  always_ff @(posedge clk) begin
    if (rst || clr) code_q <= '0;
    else if (stepped) begin
      if (req == REQ_INC) code_q <= code_q + 1'b1;
      else                code_q <= code_q - 1'b1;
    end
  end

  assign code = code_q;
endmodule

// File: rtl/ftc_flags.sv
module ftc_flags
  import ftc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic acc,
  input  req_e req,
  input  logic blocked,
  output logic lock,
  output logic sat
);
  req_e last_q;
  logic lock_q, sat_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      last_q <= REQ_HOLD;
      lock_q <= 1'b0;
      sat_q  <= 1'b0;
    end else if (acc) begin
      last_q <= req;
      sat_q  <= blocked;
      if (req == REQ_HOLD)      lock_q <= 1'b1;
      else if (last_q == req)   lock_q <= 1'b0;
      else if (last_q != REQ_HOLD) lock_q <= 1'b1;
    end
  end

  assign lock = lock_q;
  assign sat  = sat_q;
endmodule

// File: rtl/fine_track_ctrl.sv
module fine_track_ctrl
  import ftc_pkg::*;
#(
  parameter int CODE_W  = 5,
  parameter int MIN_GAP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coarse_done,
  input  logic              dec_vld,
  input  logic              pd_up,
  input  logic              pd_dn,
  output logic [CODE_W-1:0] fine_code,
  output logic              fine_lock,
  output logic              fine_sat
);
  req_e req;
  logic ready, acc, blocked, stepped, idle;

  assign idle = !coarse_done;
  assign acc  = coarse_done && dec_vld && ready;

  ftc_classify u_cls (.up(pd_up), .dn(pd_dn), .req(req));

  ftc_pacer #(.MIN_GAP(MIN_GAP)) u_pace (
    .clk(clk), .rst(rst), .clr(idle), .load(stepped), .ready(ready)
  );

  ftc_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .clr(idle), .acc(acc), .req(req),
    .code(fine_code), .blocked(blocked), .stepped(stepped)
  );

  ftc_flags u_flg (
    .clk(clk), .rst(rst), .clr(idle), .acc(acc), .req(req),
    .blocked(blocked), .lock(fine_lock), .sat(fine_sat)
  );
endmodule

// File: rtl/ftc_chk.sv
module ftc_chk #(
  parameter int CODE_W  = 5,
  parameter int MIN_GAP = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              coarse_done,
  input logic [CODE_W-1:0] fine_code,
  input logic              fine_lock,
  input logic              fine_sat
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
  logic [CODE_W-1:0] prev_q;
  logic armed_q;
  int unsigned since_q;
  logic chg;

  always_ff @(posedge clk) prev_q <= fine_code;
  assign chg = (fine_code != prev_q);

  always_ff @(posedge clk) begin
    if (rst || !coarse_done) begin
      armed_q <= 1'b0;
      since_q <= 0;
    end else if (chg) begin
      armed_q <= 1'b1;
      since_q <= 0;
    end else if (since_q < MIN_GAP) begin
      since_q <= since_q + 1;
    end
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !coarse_done |=> (fine_code == '0 && !fine_lock && !fine_sat));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    coarse_done |=> ({1'b0, fine_code} == {1'b0, $past(fine_code)} ||
                     {1'b0, fine_code} == {1'b0, $past(fine_code)} + 1'b1 ||
                     {1'b0, fine_code} + 1'b1 == {1'b0, $past(fine_code)}));

  assert_gap_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (chg && armed_q) |-> (since_q >= MIN_GAP));

  assert_sat_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    fine_sat |-> (fine_code == '0 || fine_code == TOP));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (fine_code == '0 && !fine_lock && !fine_sat));
endmodule

bind fine_track_ctrl ftc_chk #(.CODE_W(CODE_W), .MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rst(rst), .coarse_done(coarse_done), .fine_code(fine_code),
  .fine_lock(fine_lock), .fine_sat(fine_sat)
);

// File: tb/sim_fine_track_ctrl.sv
module sim_fine_track_ctrl;
  localparam int CODE_W  = 5;
  localparam int MIN_GAP = 3;
  localparam int TOPV    = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coarse_done = 1'b0, dec_vld = 1'b0, pd_up = 1'b0, pd_dn = 1'b0;
  logic [CODE_W-1:0] fine_code;
  logic fine_lock, fine_sat;

  always #2.5 clk = ~clk;

  fine_track_ctrl #(.CODE_W(CODE_W), .MIN_GAP(MIN_GAP)) u0 (
    .clk(clk), .rst(rst), .coarse_done(coarse_done), .dec_vld(dec_vld),
    .pd_up(pd_up), .pd_dn(pd_dn), .fine_code(fine_code),
    .fine_lock(fine_lock), .fine_sat(fine_sat)
  );

  typedef struct {
    int    code;
    bit    lock;
    bit    sat;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int m_code = 0, m_gap = 0, m_last = 0;
  bit m_lock = 0, m_sat = 0;

  task automatic cyc(input bit cd, input bit v, input bit u, input bit d, input string tag);
    exp_t e;
    int rq;
    @(negedge clk);
    coarse_done = cd; dec_vld = v; pd_up = u; pd_dn = d;
    if (!cd) begin
      m_code = 0; m_lock = 0; m_sat = 0; m_last = 0; m_gap = 0;
    end else begin
      bit acc, stepped;
      acc = v && (m_gap == 0);
      stepped = 0;
      if (acc) begin
        rq = (u && !d) ? 1 : ((d && !u) ? 2 : 0);
        if (rq == 0) begin
          m_lock = 1; m_sat = 0;
        end else begin
          if ((rq == 1 && m_code == TOPV) || (rq == 2 && m_code == 0)) m_sat = 1;
          else begin
            m_sat = 0; stepped = 1;
            m_code = (rq == 1) ? m_code + 1 : m_code - 1;
          end
          if (m_last == rq) m_lock = 0;
          else if (m_last != 0) m_lock = 1;
        end
        m_last = rq;
      end
      if (stepped) m_gap = MIN_GAP;
      else if (m_gap > 0) m_gap = m_gap - 1;
    end
    e.code = m_code; e.lock = m_lock; e.sat = m_sat; e.tag = tag;
    q.push_back(e);
  endtask

  // behavioural delay model: detector compares code with target delay code
  task automatic track(input int target, input int n, input string tag);
    for (int i = 0; i < n; i++)
      cyc(1, 1, m_code < target, m_code > target, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (fine_code != e.code[CODE_W-1:0] || fine_lock != e.lock || fine_sat != e.sat) begin
          bad++;
          $display("FAIL %s: got code=%0d lock=%0b sat=%0b expected code=%0d lock=%0b sat=%0b",
                   e.tag, fine_code, fine_lock, fine_sat, e.code, e.lock, e.sat);
        end
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (fine_code != 0 || fine_lock || fine_sat) begin
      bad++;
      $display("FAIL R1: got code=%0d lock=%0b sat=%0b expected 0 0 0", fine_code, fine_lock, fine_sat);
    end
    // R2: idle while coarse loop not done
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 0, "R2 idle");
    // R9: no strobe, no effect
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, "R9 no strobe");
    // R3/R5: climb to target 6 with strobe every cycle (gap drops some)
    track(6, 40, "R3 R5 climb");
    // R4: both asserted -> balanced
    cyc(1, 1, 1, 1, "R4 both");
    cyc(1, 1, 0, 0, "R4 none");
    // R7: reversal sets lock
    track(4, 20, "R7 reversal");
    // R8: later drift followed without restart
    track(12, 50, "R8 retrack");
    // R6: saturate high
    track(40, 150, "R6 top");
    cyc(1, 1, 0, 0, "R6 clear");
    // R6: saturate low
    track(-5, 160, "R6 bottom");
    // R5: sparse strobes inside gap
    for (int i = 0; i < 8; i++) begin
      cyc(1, 1, 1, 0, "R5 gap");
      cyc(1, 0, 0, 1, "R9 gap idle");
    end
    // R2: drop coarse-done
    cyc(0, 1, 1, 0, "R2 drop");
    cyc(0, 1, 1, 0, "R2 drop hold");
    track(3, 20, "R8 restart");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule